// File: doc/BRIEF.md
# Multiplexed Bus Cycle Generator

This block runs a single external machine cycle for an 8-bit processor whose lower address byte and data byte share one set of pins. A request gives a cycle kind, a 16-bit address and a byte to write. The block then steps through the T-states that kind needs. It raises the address latch strobe, drives the active-low read, write and interrupt-acknowledge strobes, and presents the I/O-versus-memory flag and two status bits. The high address byte has its own bus. The shared low byte carries the address in T1 and data afterwards.

For read-type cycles, the byte on the shared bus is captured and presented to the core. Every cycle ends with a one-clock completion pulse. A new request may be placed during the final T-state, so cycles can run back to back with no gap. A request made at any other time while a cycle runs is ignored.

Top module: `busCycleGen`

## Requirements
- R1: After reset, `ale` is 0, `rdN`, `wrN` and `intaN` are 1, `adOe`, `done` and `busy` are 0, and `{ioM,s1,s0}` is 000.
- R2: Cycle kind codes are 0 opcode fetch, 1 memory read, 2 memory write, 3 I/O read, 4 I/O write, 5 interrupt acknowledge and 6 bus idle. A cycle accepted on a clock edge has T1 in the following clock. It lasts 4 T-states for fetch, 6 for interrupt acknowledge and 3 for every other kind. `done` is high for exactly the one clock after the last T-state, and `busy` is high exactly during the T-states.
- R3: `ale` is high only in T1 of a transfer cycle (any kind except bus idle). It is never high during bus idle.
- R4: In T1 of a transfer cycle, `addrHi` equals address bits 15:8, `adOut` equals address bits 7:0, and `adOe` is 1.
- R5: `rdN` is low exactly in T2 and T3 of fetch, memory read and I/O read. It is high in T1 and in T4 of a fetch.
- R6: `wrN` is low exactly in T2 and T3 of memory write and I/O write. In those T-states `adOut` carries the write byte with `adOe`=1. `rdN` and `wrN` are never low together.
- R7: `intaN` is low exactly in T2 and T3 of interrupt acknowledge, and `rdN` stays high for that whole cycle.
- R8: `{ioM,s1,s0}` is held through each cycle as follows: fetch 011, memory read 010, memory write 001, I/O read 110, I/O write 101, interrupt acknowledge 111, bus idle 000. It is 000 when no cycle runs.
- R9: In read and acknowledge cycles, `adOe` is 0 from T2 to the end of the cycle. The byte on `adIn` is captured on the clock edge that ends T3, and it appears on `rdData` from the `done` clock onward.
- R10: A start request is ignored while a cycle is in any T-state other than its last. The cycle continues unchanged and no new cycle follows.
- R11: A start request in the last T-state is accepted. The next clock is T1 of the new cycle and coincides with `done`.
- R12: Code 7 behaves exactly like bus idle: 3 T-states, no strobes, `adOe` 0, status 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per period |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new machine cycle |
| cycType | input | 3 | Kind of the requested cycle |
| addr | input | 16 | Address of the cycle |
| wrData | input | 8 | Byte written by write cycles |
| adIn | input | 8 | Shared bus value seen from outside |
| addrHi | output | 8 | Dedicated high address bus |
| adOut | output | 8 | Shared bus value driven by the block |
| adOe | output | 1 | Enable for driving the shared bus |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| intaN | output | 1 | Active-low interrupt acknowledge |
| ioM | output | 1 | High for I/O, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 8 | Byte captured by the last read |

## Verification
Every cycle kind is run with its own address, write byte and shared-bus byte, and every strobe and status pin is compared in every T-state. This separates the kinds by length, by which strobe falls, and by when the shared bus changes from address to data or to high impedance. Distinct address and data bytes show whether the shared bus carries the right field at the right T-state. Directed runs then place a request in the middle of a cycle and in its last T-state, which separates ignored requests from chained ones. A further run uses the unused code 7 to confirm it falls back to bus idle.

// File: rtl/busPkg.sv
package busPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int KIND_W = 3;
  localparam int TST_W  = 3;

  localparam logic [KIND_W-1:0] K_FETCH = 3'd0;
  localparam logic [KIND_W-1:0] K_MRD   = 3'd1;
  localparam logic [KIND_W-1:0] K_MWR   = 3'd2;
  localparam logic [KIND_W-1:0] K_IORD  = 3'd3;
  localparam logic [KIND_W-1:0] K_IOWR  = 3'd4;
  localparam logic [KIND_W-1:0] K_INTA  = 3'd5;
  localparam logic [KIND_W-1:0] K_IDLE  = 3'd6;

  // strobes passed from sequencing control to the datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic drvAddr;  // low address on shared bus
    logic drvData;  // write byte on shared bus
    logic capture;  // sample shared bus into read register
  } dpCtl_t;
endpackage

// File: rtl/cycCtl.sv
module cycCtl
  import busPkg::*;
#(
  parameter int FETCH_T = 4,
  parameter int ACK_T   = 6,
  parameter int XFER_T  = 3,
  parameter int IDLE_T  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [KIND_W-1:0] cycType,
  output dpCtl_t            dpCtl,
  output logic              ale,
  output logic              rdEn,
  output logic              wrEn,
  output logic              intaEn,
  output logic              ioM,
  output logic              s1,
  output logic              s0,
  output logic              busy,
  output logic              done
);
  logic [TST_W-1:0]  tState;
  logic [KIND_W-1:0] curType;
  logic [TST_W-1:0]  curLen;
  logic isRead, isWrite, isAck, isXfer, lastT, accept, midT;

  always_comb begin
    unique case (curType)
      K_FETCH: curLen = TST_W'(FETCH_T);
      K_INTA:  curLen = TST_W'(ACK_T);
      K_MRD, K_MWR, K_IORD, K_IOWR: curLen = TST_W'(XFER_T);
      default: curLen = TST_W'(IDLE_T);
    endcase
  end

  assign isRead  = (curType == K_FETCH) || (curType == K_MRD) || (curType == K_IORD);
  assign isWrite = (curType == K_MWR) || (curType == K_IOWR);
  assign isAck   = (curType == K_INTA);
  assign isXfer  = isRead || isWrite || isAck;
  assign busy    = (tState != '0);
  assign lastT   = busy && (tState == curLen);
  assign accept  = start && (!busy || lastT);
  assign midT    = (tState == TST_W'(2)) || (tState == TST_W'(3));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tState  <= '0;
      curType <= K_IDLE;
      done    <= 1'b0;
    end else begin
      done <= lastT;
      if (accept) begin
        tState  <= TST_W'(1);
        curType <= cycType;
      end else if (lastT) begin
        tState <= '0;
      end else if (busy) begin
        tState <= tState + TST_W'(1);
      end
    end
  end

  assign ale    = isXfer && (tState == TST_W'(1));
  assign rdEn   = isRead && midT;
  assign wrEn   = isWrite && midT;
  assign intaEn = isAck && midT;

  assign dpCtl.load    = accept;
  assign dpCtl.drvAddr = ale;
  assign dpCtl.drvData = wrEn;
  assign dpCtl.capture = (isRead || isAck) && (tState == TST_W'(3));

  always_comb begin
    {ioM, s1, s0} = 3'b000;
    if (busy) begin
      unique case (curType)
        K_FETCH: {ioM, s1, s0} = 3'b011;
        K_MRD:   {ioM, s1, s0} = 3'b010;
        K_MWR:   {ioM, s1, s0} = 3'b001;
        K_IORD:  {ioM, s1, s0} = 3'b110;
        K_IOWR:  {ioM, s1, s0} = 3'b101;
        K_INTA:  {ioM, s1, s0} = 3'b111;
        default: {ioM, s1, s0} = 3'b000;
      endcase
    end
  end
endmodule

// File: rtl/busDp.sv
module busDp
  import busPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        dpCtl,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] adIn,
  output logic [AW-DW-1:0] addrHi,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  output logic [DW-1:0] rdData
);
  localparam int HI_W = AW - DW;
  logic [AW-1:0] addrReg;
  logic [DW-1:0] wrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      wrReg   <= '0;
      rdData  <= '0;
    end else begin
      if (dpCtl.load) begin
        addrReg <= addr;
        wrReg   <= wrData;
      end
      if (dpCtl.capture) rdData <= adIn;
    end
  end

  assign addrHi = addrReg[AW-1 -: HI_W];
  assign adOut  = dpCtl.drvAddr ? addrReg[DW-1:0] : wrReg;
  assign adOe   = dpCtl.drvAddr || dpCtl.drvData;
endmodule

// File: rtl/busCycleGen.sv
module busCycleGen
  import busPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [2:0]  cycType,
  input  logic [15:0] addr,
  input  logic [7:0]  wrData,
  input  logic [7:0]  adIn,
  output logic [7:0]  addrHi,
  output logic [7:0]  adOut,
  output logic        adOe,
  output logic        ale,
  output logic        rdN,
  output logic        wrN,
  output logic        intaN,
  output logic        ioM,
  output logic        s1,
  output logic        s0,
  output logic        busy,
  output logic        done,
  output logic [7:0]  rdData
);
  dpCtl_t dpCtl;
  logic rdEn, wrEn, intaEn;

  cycCtl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .cycType(cycType),
    .dpCtl(dpCtl), .ale(ale), .rdEn(rdEn), .wrEn(wrEn), .intaEn(intaEn),
    .ioM(ioM), .s1(s1), .s0(s0), .busy(busy), .done(done)
  );

  busDp #(.AW(ADDR_W), .DW(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .addr(addr), .wrData(wrData),
    .adIn(adIn), .addrHi(addrHi), .adOut(adOut), .adOe(adOe), .rdData(rdData)
  );

  assign rdN   = ~rdEn;
  assign wrN   = ~wrEn;
  assign intaN = ~intaEn;
endmodule

// File: rtl/busCycleGenChk.sv
module busCycleGenChk (
  input logic clk,
  input logic rstN,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic intaN,
  input logic adOe,
  input logic ioM,
  input logic s1,
  input logic s0,
  input logic busy,
  input logic done
);
  p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_wr_drives_bus_r6: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |-> adOe);
  p_ale_one_clock_r3: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_rd_after_ale_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> $past(ale));
  p_ack_no_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    !intaN |-> rdN);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_status_held_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !ale && $past(busy)) |-> $stable({ioM, s1, s0}));
  p_quiet_between_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ale && rdN && wrN && intaN && !adOe));
endmodule

bind busCycleGen busCycleGenChk u_chk (
  .clk(clk), .rstN(rstN), .ale(ale), .rdN(rdN), .wrN(wrN), .intaN(intaN),
  .adOe(adOe), .ioM(ioM), .s1(s1), .s0(s0), .busy(busy), .done(done)
);

// File: tb/sim_busCycleGen.sv
module sim_busCycleGen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {kind[2:0], addr[15:0], write byte[7:0], shared-bus byte[7:0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {3'd0, 16'h4045, 8'h11, 8'h3A},
    {3'd1, 16'h2050, 8'h22, 8'hC7},
    {3'd2, 16'h526A, 8'hC7, 8'h00},
    {3'd3, 16'h0081, 8'h33, 8'h5E},
    {3'd4, 16'h00F2, 8'hA5, 8'h44},
    {3'd5, 16'h9ABC, 8'h55, 8'hFF},
    {3'd6, 16'h1357, 8'h66, 8'h77},
    {3'd1, 16'hFF00, 8'h99, 8'h0F}
  };

  logic clk = 0, rstN = 0, start = 0;
  logic [2:0] cycType = 0;
  logic [15:0] addr = 0;
  logic [7:0] wrData = 0, adIn = 0;
  logic [7:0] addrHi, adOut, rdData;
  logic adOe, ale, rdN, wrN, intaN, ioM, s1, s0, busy, done;
  int nChk = 0, nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busCycleGen u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lenOf(input logic [2:0] k);
    return (k == 3'd0) ? 4 : (k == 3'd5) ? 6 : 3;
  endfunction

  function automatic logic [2:0] statOf(input logic [2:0] k);
    case (k)
      3'd0: return 3'b011;
      3'd1: return 3'b010;
      3'd2: return 3'b001;
      3'd3: return 3'b110;
      3'd4: return 3'b101;
      3'd5: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  // called at a negedge inside T-state t of a cycle of kind k
  task automatic chkT(input logic [2:0] k, input int t, input logic [15:0] a,
                      input logic [7:0] wd);
    logic xfer, rd, wr, ack, mid;
    xfer = (k <= 3'd5);
    rd   = (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
    wr   = (k == 3'd2) || (k == 3'd4);
    ack  = (k == 3'd5);
    mid  = (t == 2) || (t == 3);
    chk("R2 busy", busy, 1);
    chk("R3 ale", ale, xfer && t == 1);
    chk("R5 rdN", rdN, !(rd && mid));
    chk("R6 wrN", wrN, !(wr && mid));
    chk("R7 intaN", intaN, !(ack && mid));
    chk("R8 status", {ioM, s1, s0}, statOf(k));
    if (xfer && t == 1) begin
      chk("R4 addrHi", addrHi, a[15:8]);
      chk("R4 adOut", adOut, a[7:0]);
      chk("R4 adOe", adOe, 1);
    end else if (wr && mid) begin
      chk("R6 data", adOut, wd);
      chk("R6 adOe", adOe, 1);
    end else begin
      chk("R9 R12 adOe off", adOe, 0);
    end
  endtask

  task automatic runCycle(input logic [2:0] k, input logic [15:0] a,
                          input logic [7:0] wd, input logic [7:0] bus);
    @(negedge clk);
    start = 1; cycType = k; addr = a; wrData = wd; adIn = bus;
    @(negedge clk);
    start = 0;
    for (int t = 1; t <= lenOf(k); t++) begin
      chkT(k, t, a, wd);
      @(negedge clk);
    end
    chk("R2 done", done, 1);
    chk("R2 busy end", busy, 0);
    if (k == 3'd0 || k == 3'd1 || k == 3'd3 || k == 3'd5)
      chk("R9 rdData", rdData, bus);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ale", ale, 0);
    chk("R1 strobes", {rdN, wrN, intaN}, 3'b111);
    chk("R1 adOe done busy", {adOe, done, busy}, 3'b000);
    chk("R1 status", {ioM, s1, s0}, 3'b000);
    rstN = 1;

    for (int i = 0; i < NVEC; i++)
      runCycle(VEC[i][34:32], VEC[i][31:16], VEC[i][15:8], VEC[i][7:0]);

    // R12 unused code acts as idle
    runCycle(3'd7, 16'hBEEF, 8'h12, 8'h34);

    // R10 request during T2 is ignored
    @(negedge clk);
    start = 1; cycType = 3'd1; addr = 16'h1234; adIn = 8'h6B;
    @(negedge clk);
    start = 0;                                 // T1
    @(negedge clk);                            // T2
    start = 1; cycType = 3'd4; addr = 16'h8888; wrData = 8'hEE;
    @(negedge clk);                            // T3, request was seen in T2
    start = 0;
    chk("R10 still read", {ioM, s1, s0}, 3'b010);
    chk("R10 rdN", rdN, 0);
    @(negedge clk);
    chk("R10 done", done, 1);
    chk("R10 rdData", rdData, 8'h6B);
    @(negedge clk);
    chk("R10 no new cycle", busy, 0);
    chk("R10 no ale", ale, 0);

    // R11 request in last T-state chains a cycle
    start = 1; cycType = 3'd2; addr = 16'h4321; wrData = 8'h5A;
    @(negedge clk);
    start = 0;                                 // T1 write
    @(negedge clk);                            // T2
    @(negedge clk);                            // T3 (last)
    start = 1; cycType = 3'd4; addr = 16'h00C3; wrData = 8'h81;
    @(negedge clk);
    start = 0;
    chk("R11 done", done, 1);
    chk("R11 ale", ale, 1);
    chk("R11 adOut", adOut, 8'hC3);
    chk("R11 status", {ioM, s1, s0}, 3'b101);
    @(negedge clk);
    chk("R11 wrN", wrN, 0);
    chk("R11 data", adOut, 8'h81);
    repeat (3) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule